// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns one flash request into the raw bus cycles a NAND device expects. A request carries an opcode, an optional column and an optional page (row) address. The block first sends the command byte or bytes with the command latch high. It then sends the column byte and the row bytes with the address latch high, and each byte is strobed by an active-low write pulse. After the address phase it applies a per-opcode wait rule on the device's ready/busy line, and it reports completion with a one-cycle done pulse.

For a program-load opcode the block works out, from the column, which read-area pointer opcode must go out first, and it rebases the column to match. For read opcodes that carry a page address, it keeps the chip enable forced low from the first row byte until busy ends or a programmable limit runs out. A timeout flag records when the limit ran out. Clock frequency, write-pulse widths and the tWB hold-off are parameters.

Top module: `nand_cmd_seq`

## Requirements
- R1: A request is taken only at a clock edge where `req_ready` (high only when idle) and `req_valid` are both high; a request offered while busy is ignored. Every accepted request starts with command bytes (CLE=1, ALE=0). CLE and ALE are never high in the same cycle.
- R2: For opcode 0x80, a pointer opcode is sent first, ahead of 0x80. It is 0x50 when the column is at or above PAGE_SIZE, and the column then becomes column-PAGE_SIZE. It is 0x00 when the column is below 256 or absent. Otherwise it is 0x01, and the column becomes column-256.
- R3: The address phase runs only when a column or a page is present. ALE stays high for every byte of it. The column byte comes first, then the row bytes.
- R4: The column byte is bits 7:0 of the (rebased) column. With `cfg_bus16`=1 the column is first shifted right by one, except for opcodes 0x90, 0xEC, 0xEE and 0xEF.
- R5: Row bytes go out as page bits 7:0, then page bits 15:8, then, only when `cfg_row3`=1, a third byte {4'h0, page bits 19:16}.
- R6: Each byte occupies WE_LOW_CYC+WE_HIGH_CYC cycles with CE_n low and `nand_io_oe` high. WE_n is low for the first WE_LOW_CYC cycles and high for the rest, and `nand_io_out` = {8'h00, byte} is steady for the whole byte. Outside bytes `nand_io_oe`=0 and `nand_io_out`=0.
- R7: For opcodes 0x00, 0x01 and 0x50 with a page present, CE_n stays low from the end of the first row byte through the whole busy wait. In every other wait cycle CE_n is high, and CE_n is high during done.
- R8: Opcodes that wait hold off sampling `nand_rb` for ceil(TWB_NS*CLK_MHZ/1000) cycles (5 at the defaults) after the last byte.
- R9: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 raise done in the cycle right after their last byte, whatever `nand_rb` is.
- R10: In the bounded wait of R7, `nand_rb` is sampled each cycle. If it has not gone high after `cfg_rd_limit`*CLK_MHZ busy poll cycles, done is raised with `timeout`=1. A limit of 0 times out on the first busy sample.
- R11: All other opcodes (0xFF, and reads without a page) wait with no limit until `nand_rb`=1, and finish with `timeout`=0.
- R12: After reset the block is idle (CE_n=1, WE_n=1, `req_ready`=1, done=0). Done lasts one cycle and is followed by idle. `timeout` is valid in the done cycle and holds until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_opcode | input | 8 | Command opcode |
| req_has_col | input | 1 | Column present |
| req_col | input | COL_W | Column address |
| req_has_page | input | 1 | Page address present |
| req_page | input | 20 | Page (row) address |
| cfg_bus16 | input | 1 | 16-bit device bus |
| cfg_row3 | input | 1 | Send third row byte |
| cfg_rd_limit | input | LIMIT_W | Read busy limit in microseconds |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io_out | output | 16 | Bus data out |
| nand_io_oe | output | 1 | Bus data drive enable |
| done | output | 1 | Request finished (one cycle) |
| timeout | output | 1 | Bounded read wait expired |

## Verification
A wrong byte index or a wrong latch phase shows up as a wrong value or a wrong CLE/ALE level on the very next byte cycle, at most four clocks after the error. A bad chip-enable hold flag shows up as CE_n at the wrong level in the first tWB cycle after the address phase. Errors in the wait counters show up as done arriving one or more cycles early or late, or as a wrong timeout flag. The bench reference predicts every port every cycle, so each of these is caught in the cycle where it first appears.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

    localparam int ROW_BITS = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_TWB,
        ST_POLL,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] OP_PTR_LO    = 8'h00;
    localparam logic [7:0] OP_PTR_HI    = 8'h01;
    localparam logic [7:0] OP_PTR_SPARE = 8'h50;
    localparam logic [7:0] OP_LOAD      = 8'h80;
    localparam logic [7:0] OP_PROG      = 8'h10;
    localparam logic [7:0] OP_ERASE_A   = 8'h60;
    localparam logic [7:0] OP_ERASE_B   = 8'hD0;
    localparam logic [7:0] OP_STAT      = 8'h70;
    localparam logic [7:0] OP_IDENT     = 8'h90;
    localparam logic [7:0] OP_PARAMS    = 8'hEC;
    localparam logic [7:0] OP_FEAT_RD   = 8'hEE;
    localparam logic [7:0] OP_FEAT_WR   = 8'hEF;

endpackage

// File: rtl/nand_req_decode.sv
`timescale 1ns/1ps
module nand_req_decode
    import nand_seq_pkg::*;
#(
    parameter int PAGE_SIZE = 2048,
    parameter int COL_W     = 12
) (
    input  logic [7:0]          opcode,
    input  logic                has_col,
    input  logic [COL_W-1:0]    col,
    input  logic                has_page,
    input  logic [ROW_BITS-1:0] page,
    input  logic                bus16,
    input  logic                row3,
    output logic [1:0][7:0]     cmd_bytes,
    output logic                two_cmd,
    output logic [3:0][7:0]     addr_bytes,
    output logic [2:0]          addr_cnt,
    output logic [1:0]          page_idx
);

    localparam logic [COL_W-1:0] PAGE_LIM = COL_W'(PAGE_SIZE);
    localparam logic [COL_W-1:0] HALF_LIM = COL_W'(256);

    logic [COL_W-1:0] col_eff;
    logic [COL_W-1:0] col_adj;
    logic [COL_W-1:0] col_sh;
    logic             narrow_only;
    logic             unused_col_hi;

    // pointer choice and column rebase for program-load
    always_comb begin
        col_eff      = has_col ? col : '0;
        col_adj      = col_eff;
        two_cmd      = 1'b0;
        cmd_bytes[0] = opcode;
        cmd_bytes[1] = opcode;
        if (opcode == OP_LOAD) begin
            two_cmd = 1'b1;
            if (col_eff >= PAGE_LIM) begin
                cmd_bytes[0] = OP_PTR_SPARE;
                col_adj      = col_eff - PAGE_LIM;
            end else if (col_eff < HALF_LIM) begin
                cmd_bytes[0] = OP_PTR_LO;
            end else begin
                cmd_bytes[0] = OP_PTR_HI;
                col_adj      = col_eff - HALF_LIM;
            end
        end
    end

    always_comb begin
        narrow_only = (opcode == OP_IDENT)   || (opcode == OP_PARAMS) ||
                      (opcode == OP_FEAT_RD) || (opcode == OP_FEAT_WR);
        col_sh      = (bus16 && !narrow_only) ? (col_adj >> 1) : col_adj;
    end

    assign unused_col_hi = ^col_sh[COL_W-1:8];

    // address byte list: column first, then row bytes
    always_comb begin
        addr_bytes = '0;
        addr_cnt   = 3'd0;
        page_idx   = has_col ? 2'd1 : 2'd0;
        if (has_col) begin
            addr_bytes[0] = col_sh[7:0];
            addr_cnt      = 3'd1;
        end
        if (has_page) begin
            addr_bytes[page_idx]              = page[7:0];
            addr_bytes[2'(page_idx + 2'd1)]   = page[15:8];
            addr_cnt                          = addr_cnt + 3'd2;
            if (row3) begin
                addr_bytes[2'(page_idx + 2'd2)] = {4'h0, page[19:16]};
                addr_cnt                        = addr_cnt + 3'd1;
            end
        end
    end

endmodule

// File: rtl/nand_post_class.sv
`timescale 1ns/1ps
module nand_post_class
    import nand_seq_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       has_page,
    output logic       no_wait,
    output logic       bounded
);

    logic is_read;

    always_comb begin
        no_wait = (opcode == OP_PROG)    || (opcode == OP_ERASE_A) ||
                  (opcode == OP_ERASE_B) || (opcode == OP_LOAD)    ||
                  (opcode == OP_STAT);
        is_read = (opcode == OP_PTR_LO)  || (opcode == OP_PTR_HI)  ||
                  (opcode == OP_PTR_SPARE);
        bounded = is_read && has_page;
    end

endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int CLK_MHZ     = 50,
    parameter int PAGE_SIZE   = 2048,
    parameter int COL_W       = $clog2(PAGE_SIZE) + 1,
    parameter int WE_LOW_CYC  = 2,
    parameter int WE_HIGH_CYC = 2,
    parameter int TWB_NS      = 100,
    parameter int LIMIT_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [7:0]          req_opcode,
    input  logic                req_has_col,
    input  logic [COL_W-1:0]    req_col,
    input  logic                req_has_page,
    input  logic [ROW_BITS-1:0] req_page,
    input  logic                cfg_bus16,
    input  logic                cfg_row3,
    input  logic [LIMIT_W-1:0]  cfg_rd_limit,
    input  logic                nand_rb,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_ce_n,
    output logic                nand_we_n,
    output logic [15:0]         nand_io_out,
    output logic                nand_io_oe,
    output logic                done,
    output logic                timeout
);

    localparam int BYTE_CYC = WE_LOW_CYC + WE_HIGH_CYC;
    localparam int PC_W     = $clog2(BYTE_CYC + 1);
    localparam int TWB_CYC  = (TWB_NS * CLK_MHZ + 999) / 1000;
    localparam int TW_W     = $clog2(TWB_CYC + 1);
    localparam int STEP     = CLK_MHZ;
    localparam int SUB_W    = $clog2(STEP + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [1:0][7:0]    cmd;
        logic               two_cmd;
        logic [3:0][7:0]    adr;
        logic [2:0]         adr_cnt;
        logic [1:0]         pg_idx;
        logic               no_wait;
        logic               bounded;
        logic [LIMIT_W-1:0] lim;
        logic [1:0]         idx;
        logic [PC_W-1:0]    pc;
        logic [TW_W-1:0]    tw;
        logic [SUB_W-1:0]   sub;
        logic [LIMIT_W-1:0] us;
        logic               force_ce;
        logic               tout;
    } seq_t;

    seq_t q, d;

    logic [1:0][7:0] dec_cmd;
    logic            dec_two;
    logic [3:0][7:0] dec_adr;
    logic [2:0]      dec_cnt;
    logic [1:0]      dec_pg;
    logic            cls_no_wait;
    logic            cls_bounded;

    nand_req_decode #(
        .PAGE_SIZE (PAGE_SIZE),
        .COL_W     (COL_W)
    ) u_decode (
        .opcode     (req_opcode),
        .has_col    (req_has_col),
        .col        (req_col),
        .has_page   (req_has_page),
        .page       (req_page),
        .bus16      (cfg_bus16),
        .row3       (cfg_row3),
        .cmd_bytes  (dec_cmd),
        .two_cmd    (dec_two),
        .addr_bytes (dec_adr),
        .addr_cnt   (dec_cnt),
        .page_idx   (dec_pg)
    );

    nand_post_class u_class (
        .opcode   (req_opcode),
        .has_page (req_has_page),
        .no_wait  (cls_no_wait),
        .bounded  (cls_bounded)
    );

    logic       byte_end;
    logic       cmd_last;
    logic       adr_last;
    seq_state_e post_st;

    always_comb begin
        d        = q;
        byte_end = (q.pc == PC_W'(BYTE_CYC - 1));
        cmd_last = (q.idx == {1'b0, q.two_cmd});
        adr_last = ({1'b0, q.idx} == (q.adr_cnt - 3'd1));
        post_st  = q.no_wait ? ST_DONE : ST_TWB;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st       = ST_CMD;
                    d.cmd      = dec_cmd;
                    d.two_cmd  = dec_two;
                    d.adr      = dec_adr;
                    d.adr_cnt  = dec_cnt;
                    d.pg_idx   = dec_pg;
                    d.no_wait  = cls_no_wait;
                    d.bounded  = cls_bounded;
                    d.lim      = cfg_rd_limit;
                    d.idx      = '0;
                    d.pc       = '0;
                    d.force_ce = 1'b0;
                    d.tout     = 1'b0;
                end
            end
            ST_CMD: begin
                d.pc = byte_end ? '0 : q.pc + PC_W'(1);
                if (byte_end) begin
                    if (!cmd_last) begin
                        d.idx = q.idx + 2'd1;
                    end else begin
                        d.idx = '0;
                        d.tw  = '0;
                        d.st  = (q.adr_cnt != 3'd0) ? ST_ADDR : post_st;
                    end
                end
            end
            ST_ADDR: begin
                d.pc = byte_end ? '0 : q.pc + PC_W'(1);
                if (byte_end) begin
                    if (q.bounded && (q.idx == q.pg_idx)) begin
                        d.force_ce = 1'b1;
                    end
                    if (!adr_last) begin
                        d.idx = q.idx + 2'd1;
                    end else begin
                        d.idx = '0;
                        d.tw  = '0;
                        d.st  = post_st;
                    end
                end
            end
            ST_TWB: begin
                if (q.tw == TW_W'(TWB_CYC - 1)) begin
                    d.st  = ST_POLL;
                    d.sub = '0;
                    d.us  = '0;
                end else begin
                    d.tw = q.tw + TW_W'(1);
                end
            end
            ST_POLL: begin
                if (nand_rb) begin
                    d.st       = ST_DONE;
                    d.force_ce = 1'b0;
                end else if (q.bounded && (q.us == q.lim)) begin
                    d.st       = ST_DONE;
                    d.tout     = 1'b1;
                    d.force_ce = 1'b0;
                end else if (q.sub == SUB_W'(STEP - 1)) begin
                    d.sub = '0;
                    d.us  = q.us + LIMIT_W'(1);
                end else begin
                    d.sub = q.sub + SUB_W'(1);
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    logic       in_byte;
    logic       in_wait;
    logic [7:0] cur_byte;

    always_comb begin
        in_byte     = (q.st == ST_CMD) || (q.st == ST_ADDR);
        in_wait     = (q.st == ST_TWB) || (q.st == ST_POLL);
        cur_byte    = (q.st == ST_CMD) ? q.cmd[q.idx[0]] : q.adr[q.idx];
        req_ready   = (q.st == ST_IDLE);
        nand_cle    = (q.st == ST_CMD);
        nand_ale    = (q.st == ST_ADDR);
        nand_we_n   = !(in_byte && (q.pc < PC_W'(WE_LOW_CYC)));
        nand_ce_n   = !(in_byte || (in_wait && q.force_ce));
        nand_io_oe  = in_byte;
        nand_io_out = in_byte ? {8'h00, cur_byte} : 16'h0000;
        done        = (q.st == ST_DONE);
        timeout     = q.tout;
    end

endmodule

// File: rtl/nand_cmd_seq_chk.sv
`timescale 1ns/1ps
module nand_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        nand_rb,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_ce_n,
    input logic        nand_we_n,
    input logic [15:0] nand_io_out,
    input logic        nand_io_oe,
    input logic        done,
    input logic        timeout
);

    // R1
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R1
    accept_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (nand_cle && !nand_ale));

    // R6
    strobe_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (!nand_ce_n && nand_io_oe));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_io_oe && $past(nand_io_oe) && $rose(nand_we_n)) |-> $stable(nand_io_out));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R10
    timeout_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> $past(!nand_rb));

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nand_ce_n && !nand_io_oe));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (.*);

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

    localparam int CLK_MHZ   = 50;
    localparam int PAGE_SIZE = 2048;
    localparam int COL_W     = 12;
    localparam int WL        = 2;
    localparam int WH        = 2;
    localparam int LIMIT_W   = 16;
    localparam int TWB       = 5;
    localparam int STEP      = 50;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [7:0]         req_opcode = 8'h00;
    logic               req_has_col = 1'b0;
    logic [COL_W-1:0]   req_col = '0;
    logic               req_has_page = 1'b0;
    logic [19:0]        req_page = '0;
    logic               cfg_bus16 = 1'b0;
    logic               cfg_row3 = 1'b0;
    logic [LIMIT_W-1:0] cfg_rd_limit = 16'd30;
    logic               nand_rb = 1'b1;
    logic               nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_io_oe;
    logic [15:0]        nand_io_out;
    logic               done, timeout;

    always #10 clk = ~clk;

    nand_cmd_seq #(
        .CLK_MHZ(CLK_MHZ), .PAGE_SIZE(PAGE_SIZE), .COL_W(COL_W),
        .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .TWB_NS(100), .LIMIT_W(LIMIT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_has_col(req_has_col), .req_col(req_col),
        .req_has_page(req_has_page), .req_page(req_page), .cfg_bus16(cfg_bus16),
        .cfg_row3(cfg_row3), .cfg_rd_limit(cfg_rd_limit), .nand_rb(nand_rb),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
        .nand_we_n(nand_we_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .done(done), .timeout(timeout)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int    q_val[$];
    int    q_kind[$];
    int    q_pg[$];
    string q_tag[$];
    int    m_st = 0;     // 0 idle, 1 byte, 2 tWB, 3 poll, 4 done
    int    m_pc, m_tw, m_poll, m_wait, m_lim;
    bit    m_force, m_tout;

    task automatic mpush(input int v, input int k, input int pg, input string t);
        q_val.push_back(v); q_kind.push_back(k); q_pg.push_back(pg); q_tag.push_back(t);
    endtask

    task automatic model_load();
        int op;
        int c;
        int pg;
        op = int'(req_opcode);
        pg = int'(req_page);
        c  = req_has_col ? int'(req_col) : 0;
        q_val.delete(); q_kind.delete(); q_pg.delete(); q_tag.delete();
        if (op == 'h80) begin
            if (c >= PAGE_SIZE) begin mpush('h50, 0, 0, "R2"); c = c - PAGE_SIZE; end
            else if (c < 256)   begin mpush('h00, 0, 0, "R2"); end
            else                begin mpush('h01, 0, 0, "R2"); c = c - 256; end
        end
        mpush(op, 0, 0, "R1");
        if (req_has_col) begin
            if (cfg_bus16 && !(op == 'h90 || op == 'hEC || op == 'hEE || op == 'hEF)) c = c / 2;
            mpush(c % 256, 1, 0, "R4");
        end
        if (req_has_page) begin
            mpush(pg % 256, 1, 1, "R5");
            mpush((pg / 256) % 256, 1, 0, "R5");
            if (cfg_row3) mpush((pg / 65536) % 16, 1, 0, "R5");
        end
        if (op == 'h10 || op == 'h60 || op == 'hD0 || op == 'h80 || op == 'h70) m_wait = 0;
        else if ((op == 'h00 || op == 'h01 || op == 'h50) && req_has_page)     m_wait = 2;
        else                                                                    m_wait = 1;
        m_lim = int'(cfg_rd_limit);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_force = 0; m_tout = 0; m_pc = 0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                       model_load();
                       m_st = 1; m_pc = 0; m_force = 0; m_tout = 0;
                   end
                1: begin
                       m_pc++;
                       if (m_pc == WL + WH) begin
                           m_pc = 0;
                           if (q_pg[0] == 1 && m_wait == 2) m_force = 1;
                           void'(q_val.pop_front()); void'(q_kind.pop_front());
                           void'(q_pg.pop_front());  void'(q_tag.pop_front());
                           if (q_val.size() == 0) begin
                               if (m_wait == 0) m_st = 4;
                               else begin m_st = 2; m_tw = 0; end
                           end
                       end
                   end
                2: begin
                       m_tw++;
                       if (m_tw == TWB) begin m_st = 3; m_poll = 0; end
                   end
                3: begin
                       if (nand_rb) begin m_st = 4; m_force = 0; end
                       else if (m_wait == 2 && m_poll == m_lim * STEP) begin
                           m_st = 4; m_tout = 1; m_force = 0;
                       end else m_poll++;
                   end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    bit cmp_on = 0;
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            bit    inb;
            int    e_io;
            string iot;
            inb  = (m_st == 1);
            e_io = inb ? q_val[0] : 0;
            iot  = inb ? q_tag[0] : "R6";
            check(req_ready === (m_st == 0), "R1", "req_ready", req_ready, m_st == 0);
            check(nand_cle === (inb && q_kind[0] == 0), "R1", "cle", nand_cle, inb && q_kind[0] == 0);
            check(nand_ale === (inb && q_kind[0] == 1), "R3", "ale", nand_ale, inb && q_kind[0] == 1);
            check(nand_we_n === !(inb && m_pc < WL), "R6", "we_n", nand_we_n, !(inb && m_pc < WL));
            check(nand_io_oe === inb, "R6", "io_oe", nand_io_oe, inb);
            check(nand_io_out === 16'(e_io), iot, "io", nand_io_out, e_io);
            check(nand_ce_n === !(inb || ((m_st == 2 || m_st == 3) && m_force)), "R7", "ce_n",
                  nand_ce_n, !(inb || ((m_st == 2 || m_st == 3) && m_force)));
            check(done === (m_st == 4), "R12", "done", done, m_st == 4);
            check(timeout === m_tout, "R10", "timeout", timeout, m_tout);
        end
    end

    // port monitors for per-request checks
    logic [63:0] cap = '0;
    int          cap_n = 0;
    int          done_cnt = 0;
    int          wait_cyc = 0;
    bit          done_tout = 0;
    bit          prev_we = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !nand_we_n) begin cap = {cap[55:0], nand_io_out[7:0]}; cap_n++; end
            prev_we = nand_we_n;
            if (done) begin done_cnt++; done_tout = timeout; end
            if (!req_ready && !nand_io_oe && !done) wait_cyc++;
        end
    end

    task automatic do_req(input string tag, input logic [7:0] op, input bit hc, input int col,
                          input bit hp, input int page, input bit b16, input bit r3,
                          input int lim, input int busy, input logic [63:0] exp_b,
                          input int exp_n, input bit exp_to, input int exp_wait, input int stray);
        @(negedge clk);
        cap = '0; cap_n = 0; done_cnt = 0; wait_cyc = 0;
        req_opcode = op; req_has_col = hc; req_col = COL_W'(col);
        req_has_page = hp; req_page = 20'(page); cfg_bus16 = b16; cfg_row3 = r3;
        cfg_rd_limit = LIMIT_W'(lim); nand_rb = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < busy; i++) begin
            if (stray > 0 && i == stray)     begin req_opcode = 8'h70; req_valid = 1'b1; end
            if (stray > 0 && i == stray + 2) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        nand_rb = 1'b1;
        while (m_st != 0) @(negedge clk);
        @(negedge clk);
        check(cap_n == exp_n, tag, "byte count", cap_n, exp_n);
        check(cap == exp_b, tag, "byte sequence", cap, exp_b);
        check(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
        check(done_tout == exp_to, tag, "timeout at done", done_tout, exp_to);
        if (exp_wait >= 0) check(wait_cyc == exp_wait, tag, "wait cycles", wait_cyc, exp_wait);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready == 1'b1 && nand_ce_n == 1'b1 && nand_we_n == 1'b1 && !done && !nand_io_oe,
              "R12", "reset idle", {req_ready, nand_ce_n, nand_we_n, done, nand_io_oe}, 5'b11100);
        cmp_on = 1;

        // R11 reset opcode, open wait
        do_req("R11", 8'hFF, 0, 0, 0, 0, 0, 0, 30, 30, 64'hFF, 1, 0, -1, 0);
        // R8 ready already high: tWB then one poll cycle
        do_req("R8", 8'hFF, 0, 0, 0, 0, 0, 0, 30, 0, 64'hFF, 1, 0, TWB + 1, 0);
        // R2 pointer 0x00, R5 three row bytes, R9 no wait
        do_req("R2", 8'h80, 1, 100, 1, 'h12345, 0, 1, 30, 40, 64'h00_80_64_45_23_01, 6, 0, 0, 0);
        // R2 pointer 0x01, column rebased by 256
        do_req("R2", 8'h80, 1, 300, 1, 'h00A07, 0, 0, 30, 40, 64'h01_80_2C_07_0A, 5, 0, 0, 0);
        // R4 pointer 0x50, rebased then halved on 16-bit bus
        do_req("R4", 8'h80, 1, 2100, 1, 'h00321, 1, 0, 30, 40, 64'h50_80_1A_21_03, 5, 0, 0, 0);
        // R7 bounded read, ready before limit
        do_req("R7", 8'h00, 1, 'hF0, 1, 'h45678, 0, 1, 30, 200, 64'h00_F0_78_56_04, 5, 0, -1, 0);
        // R10 bounded read times out at 2 us
        do_req("R10", 8'h50, 0, 0, 1, 'h000AB, 0, 0, 2, 400, 64'h50_AB_00, 3, 1, TWB + 2 * STEP + 1, 0);
        // R10 limit zero: immediate timeout
        do_req("R10", 8'h01, 0, 0, 1, 'h00010, 0, 0, 0, 100, 64'h01_10_00, 3, 1, TWB + 1, 0);
        // R11 read without page: unbounded, CE released during wait; R4 shift
        do_req("R11", 8'h00, 1, 'h30, 0, 0, 1, 0, 0, 300, 64'h00_18, 2, 0, -1, 0);
        // R4 identify opcode keeps column unshifted on 16-bit bus
        do_req("R4", 8'h90, 1, 'h20, 0, 0, 1, 0, 30, 10, 64'h90_20, 2, 0, -1, 0);
        // R9 status: done straight after the command byte though busy
        do_req("R9", 8'h70, 0, 0, 0, 0, 0, 0, 30, 20, 64'h70, 1, 0, 0, 0);
        // R5 erase with page only, third row byte
        do_req("R5", 8'h60, 0, 0, 1, 'h789AB, 0, 1, 30, 20, 64'h60_AB_89_07, 4, 0, 0, 0);
        // R3 program-load without column or page: no address phase
        do_req("R3", 8'h80, 0, 0, 0, 0, 0, 0, 30, 20, 64'h00_80, 2, 0, 0, 0);
        // R1 request offered while busy is ignored
        do_req("R1", 8'hFF, 0, 0, 0, 0, 0, 0, 30, 50, 64'hFF, 1, 0, -1, 12);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule